// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block is the slave-side receiver for a stereo PCM link made of three wires: a bit clock, a frame clock that toggles once per channel slot, and one serial data line. The three lines are brought into the core clock domain through a short synchronizer. Each rising bit-clock edge is then treated as a sampling event. Static configuration inputs select one of three slot framings and one of three word lengths. Each completed word comes out on the left or right sample port as a 24-bit value, left-aligned, together with a one-cycle strobe.

In parallel the block counts rising bit-clock edges over every frame period. It raises an error flag when the count is not one of the three legal ratios. While the flag is up, no sample strobes leave the block. The flag drops again once the link has shown two legal frames in a row. Software or a downstream mute stage can watch the flag to detect a wrong bit-clock ratio or a broken bit clock.

Top module: `sai_rx`

## Requirements
- R1: While rst_ni is low, and on the first cycles after it rises, both sample outputs are zero, both strobes are low and ratio_err_o is low.
- R2: With fmt_i = 0 (and also fmt_i = 3), a slot starts at the first rising bit-clock edge at which the frame clock differs from its value at the previous rising edge. The MSB is taken at the second rising edge of the slot, and the next W bits form the word. A low frame clock marks the left channel.
- R3: With fmt_i = 1, the MSB is taken at the first rising edge of the slot, and a high frame clock marks the left channel.
- R4: With fmt_i = 2, the word is the last W bits sampled before the frame clock changes. It is delivered at the rising edge where the change is seen, and it belongs to the channel of the slot that just ended (frame clock low = left).
- R5: wlen_i sets W: 0 gives 16 bits, 1 gives 20 bits, 2 or 3 gives 24 bits.
- R6: A word is placed MSB-first in bits 23 down to 24-W, with the bits below it zero. A sample output holds its value between its strobes, and the two strobes never pulse in the same cycle.
- R7: A frame boundary is a rising edge of the frame clock, as seen at a rising bit-clock edge. At each boundary after the first, the number of rising bit-clock edges since the previous boundary is checked. A count other than 32, 48 or 64 sets ratio_err_o. Once set, the flag clears at the second consecutive boundary with a legal count.
- R8: A word that completes while ratio_err_o is high is dropped: no strobe, and the output keeps its old value. This uses the flag's value before any update at that same boundary.
- R9: Bits sampled after reset and before the first frame-clock change produce no word. In right-justified mode, a word is produced only for a slot that began after such a change.
- R10: A strobe appears three core-clock cycles after the bit-clock rising edge that completes the word, counted from the cycle that edge first reaches the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 as 0 |
| wlen_i | input | 2 | Word length: 0 16 bit, 1 20 bit, 2/3 24 bit |
| bclk_i | input | 1 | Serial bit clock |
| lrclk_i | input | 1 | Frame clock, one period per stereo sample |
| sdata_i | input | 1 | Serial data, MSB first |
| left_data_o | output | 24 | Last accepted left sample, left-aligned |
| left_valid_o | output | 1 | One-cycle strobe for a new left sample |
| right_data_o | output | 24 | Last accepted right sample, left-aligned |
| right_valid_o | output | 1 | One-cycle strobe for a new right sample |
| ratio_err_o | output | 1 | Bit-clock to frame-clock ratio is illegal |

## Verification
The assertions assume three things. First, the frame clock and the data line change only while the bit clock is low. Second, each bit-clock level lasts at least two core cycles, so no rising edge is lost or merged in the synchronizer. Third, fmt_i and wlen_i stay constant outside reset. The stimulus follows all three: it moves the frame clock and the data together with each falling bit-clock edge, holds every bit-clock level for two core cycles, and changes the configuration only while reset is held. Ratio errors are produced by changing the number of bits per slot between frames, never by breaking these timing rules.

// File: rtl/sai_rx_pkg.sv
package sai_rx_pkg;
  localparam int SAMPLE_W = 24;

  typedef enum logic [1:0] {
    FMT_I2S  = 2'd0,
    FMT_LJ   = 2'd1,
    FMT_RJ   = 2'd2,
    FMT_RSVD = 2'd3
  } fmt_e;

  function automatic int unsigned word_bits(input logic [1:0] wl);
    case (wl)
      2'd0:    return 16;
      2'd1:    return 20;
      default: return 24;
    endcase
  endfunction
endpackage

// File: rtl/sai_rx_sync.sv
module sai_rx_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[i] <= '0;
        else         stg[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[i] <= '0;
        else         stg[i] <= stg[i-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sai_rx_ratio.sv
module sai_rx_ratio #(
  parameter int MAX_RATIO = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic frame_i,
  output logic err_o
);
  localparam int CNT_W = $clog2(2 * MAX_RATIO);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] R_LO  = CNT_W'(32);
  localparam logic [CNT_W-1:0] R_MID = CNT_W'(48);
  localparam logic [CNT_W-1:0] R_HI  = CNT_W'(64);

  logic [CNT_W-1:0] cnt_q;
  logic             have_q, err_q, good_q, legal;

  assign legal = (cnt_q == R_LO) || (cnt_q == R_MID) || (cnt_q == R_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      have_q <= 1'b0;
      err_q  <= 1'b0;
      good_q <= 1'b0;
    end else if (rise_i) begin
      if (frame_i) begin
        cnt_q  <= CNT_W'(1);
        have_q <= 1'b1;
        if (have_q) begin
          if (!legal) begin
            err_q  <= 1'b1;
            good_q <= 1'b0;
          end else if (err_q) begin
            // second legal frame in a row releases the flag
            if (good_q) begin
              err_q  <= 1'b0;
              good_q <= 1'b0;
            end else begin
              good_q <= 1'b1;
            end
          end
        end
      end else if (cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign err_o = err_q;

  AST_ERR_ON_BAD_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && frame_i && have_q && !legal) |=> err_q); // R7
  AST_ERR_MOVES_AT_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(err_q) |-> $past(rise_i && frame_i)); // R7
  AST_CLEAR_ON_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_q) |-> $past(legal && good_q)); // R7
endmodule

// File: rtl/sai_rx_deser.sv
module sai_rx_deser
  import sai_rx_pkg::*;
#(
  parameter int DW    = SAMPLE_W,
  parameter int POS_W = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    fmt_i,
  input  logic [1:0]    wlen_i,
  input  logic          rise_i,
  input  logic          change_i,
  input  logic          lr_i,
  input  logic          lr_prev_i,
  input  logic          sd_i,
  output logic [DW-1:0] word_o,
  output logic          word_vld_o,
  output logic          word_left_o
);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
  localparam int SH_W = $clog2(DW + 1);

  logic [DW-1:0]    shreg_q, sh_next;
  logic [POS_W-1:0] pos_q, pos_now, off, wbits, last_pos;
  logic [SH_W-1:0]  shamt;
  logic             synced_q, in_slot, is_lj, is_rj, in_win, shift_en;

  assign is_lj    = (fmt_i == FMT_LJ);
  assign is_rj    = (fmt_i == FMT_RJ);
  assign off      = is_lj ? '0 : POS_W'(1);
  assign wbits    = POS_W'(word_bits(wlen_i));
  assign shamt    = SH_W'(DW - int'(word_bits(wlen_i)));
  assign last_pos = off + wbits - POS_W'(1);

  assign pos_now  = change_i ? '0 : pos_q;
  assign in_slot  = synced_q | change_i;
  assign in_win   = (pos_now >= off) && (pos_now <= last_pos);
  assign shift_en = rise_i && (is_rj || in_win);
  assign sh_next  = {shreg_q[DW-2:0], sd_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q  <= '0;
      pos_q    <= '0;
      synced_q <= 1'b0;
    end else if (rise_i) begin
      if (shift_en) shreg_q <= sh_next;
      pos_q <= (pos_now == POS_MAX) ? pos_now : pos_now + 1'b1;
      if (change_i) synced_q <= 1'b1;
    end
  end

  always_comb begin
    word_vld_o  = 1'b0;
    word_o      = '0;
    word_left_o = 1'b0;
    if (is_rj) begin
      // word is complete once the slot it belonged to has ended
      word_vld_o  = rise_i && change_i && synced_q;
      word_o      = shreg_q << shamt;
      word_left_o = ~lr_prev_i;
    end else begin
      word_vld_o  = rise_i && in_slot && (pos_now == last_pos);
      word_o      = sh_next << shamt;
      word_left_o = is_lj ? lr_i : ~lr_i;
    end
  end

  AST_NO_WORD_UNSYNCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |-> (synced_q || change_i)); // R9
  AST_WORD_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |-> rise_i); // R10
endmodule

// File: rtl/sai_rx.sv
module sai_rx
  import sai_rx_pkg::*;
#(
  parameter int DW          = SAMPLE_W,
  parameter int SYNC_STAGES = 2,
  parameter int MAX_RATIO   = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    fmt_i,
  input  logic [1:0]    wlen_i,
  input  logic          bclk_i,
  input  logic          lrclk_i,
  input  logic          sdata_i,
  output logic [DW-1:0] left_data_o,
  output logic          left_valid_o,
  output logic [DW-1:0] right_data_o,
  output logic          right_valid_o,
  output logic          ratio_err_o
);
  localparam int POS_W = $clog2(2 * MAX_RATIO);

  logic [2:0]    sync_q;
  logic          s_bclk, s_lr, s_sd, bclk_d, lr_prev_q;
  logic          rise, change, frame, err;
  logic [DW-1:0] word;
  logic          word_vld, word_left;

  sai_rx_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({bclk_i, lrclk_i, sdata_i}),
    .q_o   (sync_q)
  );
  assign {s_bclk, s_lr, s_sd} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_d    <= 1'b0;
      lr_prev_q <= 1'b0;
    end else begin
      bclk_d <= s_bclk;
      if (rise) lr_prev_q <= s_lr;
    end
  end

  assign rise   = s_bclk & ~bclk_d;
  assign change = rise & (s_lr ^ lr_prev_q);
  assign frame  = change & s_lr;

  sai_rx_ratio #(.MAX_RATIO(MAX_RATIO)) u_ratio (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rise_i (rise),
    .frame_i(frame),
    .err_o  (err)
  );

  sai_rx_deser #(.DW(DW), .POS_W(POS_W)) u_deser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fmt_i      (fmt_i),
    .wlen_i     (wlen_i),
    .rise_i     (rise),
    .change_i   (change),
    .lr_i       (s_lr),
    .lr_prev_i  (lr_prev_q),
    .sd_i       (s_sd),
    .word_o     (word),
    .word_vld_o (word_vld),
    .word_left_o(word_left)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_data_o   <= '0;
      right_data_o  <= '0;
      left_valid_o  <= 1'b0;
      right_valid_o <= 1'b0;
    end else begin
      left_valid_o  <= 1'b0;
      right_valid_o <= 1'b0;
      if (word_vld && !err) begin
        if (word_left) begin
          left_data_o  <= word;
          left_valid_o <= 1'b1;
        end else begin
          right_data_o  <= word;
          right_valid_o <= 1'b1;
        end
      end
    end
  end

  assign ratio_err_o = err;

  AST_VALID_GATED_L: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_valid_o |-> !$past(ratio_err_o)); // R8
  AST_VALID_GATED_R: assert property (@(posedge clk_i) disable iff (!rst_ni)
    right_valid_o |-> !$past(ratio_err_o)); // R8
  AST_ONE_CHANNEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(left_valid_o && right_valid_o)); // R6
  AST_HOLD_L: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !left_valid_o |-> $stable(left_data_o)); // R6
  AST_HOLD_R: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !right_valid_o |-> $stable(right_data_o)); // R6
  AST_LSB_ZERO_16: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_valid_o && wlen_i == 2'd0) |-> (left_data_o[7:0] == 8'h00)); // R6
endmodule

// File: tb/sai_rx_bench.sv
module sai_rx_bench;
  typedef struct {
    logic        lv;
    logic [23:0] ld;
    logic        rv;
    logic [23:0] rd;
    logic        err;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt = 2'd0, wlen = 2'd2;
  logic        bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
  logic [23:0] ldata, rdata;
  logic        lvalid, rvalid, rerr;

  int n_checks = 0, n_fail = 0, cyc = 0;
  string cur_req = "R1";
  exp_t q[$];

  // reference state
  int m_prev_b, m_lr_prev, m_synced, m_pos, m_sh, m_cnt, m_have, m_err, m_good;
  int m_ld, m_rd;

  always #2 clk = ~clk;

  sai_rx u_sai_rx (
    .clk_i(clk), .rst_ni(rst_n), .fmt_i(fmt), .wlen_i(wlen),
    .bclk_i(bclk), .lrclk_i(lrclk), .sdata_i(sdata),
    .left_data_o(ldata), .left_valid_o(lvalid),
    .right_data_o(rdata), .right_valid_o(rvalid), .ratio_err_o(rerr)
  );

  task automatic model_reset();
    m_prev_b = 0; m_lr_prev = 0; m_synced = 0; m_pos = 0; m_sh = 0;
    m_cnt = 0; m_have = 0; m_err = 0; m_good = 0; m_ld = 0; m_rd = 0;
  endtask

  function automatic exp_t model_step(input int b, input int lr, input int sd);
    exp_t e;
    int w, off, pos, chg, emit, left, word;
    w    = (wlen == 2'd0) ? 16 : (wlen == 2'd1) ? 20 : 24;
    off  = (fmt == 2'd1) ? 0 : 1;
    e.lv = 1'b0; e.rv = 1'b0;
    if (b == 1 && m_prev_b == 0) begin
      chg  = (lr != m_lr_prev);
      pos  = chg ? 0 : m_pos;
      emit = 0; left = 0; word = 0;
      if (fmt == 2'd2) begin
        if (chg && m_synced) begin
          emit = 1; word = (m_sh << (24 - w)) & 'hFFFFFF; left = (m_lr_prev == 0);
        end
        m_sh = ((m_sh << 1) | sd) & 'hFFFFFF;
      end else if (pos >= off && pos < off + w) begin
        m_sh = ((m_sh << 1) | sd) & 'hFFFFFF;
        if (pos == off + w - 1 && (m_synced || chg)) begin
          emit = 1; word = (m_sh << (24 - w)) & 'hFFFFFF;
          left = (fmt == 2'd1) ? lr : !lr;
        end
      end
      if (emit && !m_err) begin
        if (left) begin m_ld = word; e.lv = 1'b1; end
        else      begin m_rd = word; e.rv = 1'b1; end
      end
      if (chg && lr == 1) begin
        if (m_have) begin
          if (!(m_cnt == 32 || m_cnt == 48 || m_cnt == 64)) begin
            m_err = 1; m_good = 0;
          end else if (m_err) begin
            if (m_good) begin m_err = 0; m_good = 0; end
            else m_good = 1;
          end
        end
        m_cnt = 1; m_have = 1;
      end else if (m_cnt < 127) m_cnt++;
      if (chg) m_synced = 1;
      m_pos = (pos < 127) ? pos + 1 : 127;
      m_lr_prev = lr;
    end
    m_prev_b = b;
    e.ld = m_ld[23:0]; e.rd = m_rd[23:0]; e.err = m_err[0];
    return e;
  endfunction

  task automatic compare(input exp_t e);
    bit bad = 0;
    n_checks++;
    if (lvalid !== e.lv) begin $display("FAIL %s left_valid got %b exp %b cyc %0d", cur_req, lvalid, e.lv, cyc); bad = 1; end
    if (ldata  !== e.ld) begin $display("FAIL %s left_data got %h exp %h cyc %0d", cur_req, ldata, e.ld, cyc); bad = 1; end
    if (rvalid !== e.rv) begin $display("FAIL %s right_valid got %b exp %b cyc %0d", cur_req, rvalid, e.rv, cyc); bad = 1; end
    if (rdata  !== e.rd) begin $display("FAIL %s right_data got %h exp %h cyc %0d", cur_req, rdata, e.rd, cyc); bad = 1; end
    if (rerr   !== e.err) begin $display("FAIL %s ratio_err got %b exp %b cyc %0d", cur_req, rerr, e.err, cyc); bad = 1; end
    if (bad) n_fail++;
  endtask

  // one core cycle: sample at the falling edge, then drive and predict
  task automatic tick(input logic b, input logic lr, input logic sd);
    exp_t e;
    @(negedge clk);
    cyc++;
    if (q.size() == 3) compare(q.pop_front());
    bclk = b; lrclk = lr; sdata = sd;
    e = model_step(int'(b), int'(lr), int'(sd));
    q.push_back(e);
  endtask

  task automatic do_reset(input logic [1:0] f, input logic [1:0] wl);
    exp_t z;
    z.lv = 0; z.ld = '0; z.rv = 0; z.rd = '0; z.err = 0;
    @(negedge clk);
    rst_n = 1'b0; fmt = f; wlen = wl;
    bclk = 1'b0; lrclk = 1'b0; sdata = 1'b0;
    model_reset();
    q.delete();
    repeat (3) q.push_back(z);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: quiet outputs right after reset release
    n_checks++;
    if (ldata !== '0 || rdata !== '0 || lvalid || rvalid || rerr) begin
      n_fail++;
      $display("FAIL R1 outputs after reset got %h/%h/%b/%b/%b exp 0", ldata, rdata, lvalid, rvalid, rerr);
    end
  endtask

  task automatic send_bit(input logic lr);
    logic sd;
    sd = 1'($urandom);
    tick(1'b0, lr, sd); tick(1'b0, lr, sd);
    tick(1'b1, lr, sd); tick(1'b1, lr, sd);
  endtask

  task automatic send_frame(input int slot_len);
    for (int s = 0; s < 2; s++)
      for (int p = 0; p < slot_len; p++) send_bit(logic'(s));
  endtask

  task automatic drain();
    for (int i = 0; i < 8; i++) tick(1'b0, lrclk, 1'b0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cur_req = "R1";
    do_reset(2'd0, 2'd2);
    repeat (4) tick(1'b0, 1'b0, 1'b0);

    cur_req = "R2 R10";
    for (int i = 0; i < 6; i++) send_frame(32);
    drain();

    cur_req = "R3 R6";
    do_reset(2'd1, 2'd0);
    for (int i = 0; i < 6; i++) send_frame(16);
    drain();

    cur_req = "R4 R6";
    do_reset(2'd2, 2'd1);
    for (int i = 0; i < 6; i++) send_frame(24);
    drain();

    cur_req = "R5 i2s16";
    do_reset(2'd0, 2'd0);
    for (int i = 0; i < 4; i++) send_frame(32);
    cur_req = "R5 lj24";
    do_reset(2'd1, 2'd2);
    for (int i = 0; i < 4; i++) send_frame(24);
    cur_req = "R5 fmt3 wlen3";
    do_reset(2'd3, 2'd3);
    for (int i = 0; i < 4; i++) send_frame(32);
    drain();

    cur_req = "R9 lj";
    do_reset(2'd1, 2'd0);
    for (int p = 0; p < 20; p++) send_bit(1'b0);
    for (int i = 0; i < 3; i++) send_frame(16);
    cur_req = "R9 rj";
    do_reset(2'd2, 2'd0);
    for (int p = 0; p < 10; p++) send_bit(1'b0);
    for (int p = 0; p < 16; p++) send_bit(1'b1);
    for (int i = 0; i < 3; i++) send_frame(16);
    drain();

    cur_req = "R7 R8 i2s";
    do_reset(2'd0, 2'd2);
    for (int i = 0; i < 3; i++) send_frame(32);
    for (int i = 0; i < 2; i++) send_frame(20);
    for (int i = 0; i < 5; i++) send_frame(32);
    cur_req = "R7 R8 bad-good-bad";
    send_frame(25); send_frame(32); send_frame(22); send_frame(32);
    send_frame(32); send_frame(32);
    drain();

    cur_req = "R7 R8 rj";
    do_reset(2'd2, 2'd0);
    for (int i = 0; i < 3; i++) send_frame(24);
    for (int i = 0; i < 2; i++) send_frame(50);
    for (int i = 0; i < 4; i++) send_frame(16);
    drain();

    finish_run();
  end
endmodule